// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block runs on the fast source clock that feeds two clock dividers, bank A and bank C. Each divider has its own programmable ratio. Both dividers start from a shared reset, so their rising edges line up at that instant. They line up again every time the source cycle count reaches a common multiple of the two ratios.

The block drives one registered, active-low sync signal. The signal warns downstream logic that the next joint rising edge is one period of the faster divided clock away. The pulse lasts exactly one period of that faster clock and ends on the joint edge. No least-common-multiple arithmetic is needed. Two phase counters, one per ratio, track the divided clocks. A single add-and-compare then decides whether the next edge of the faster clock is also an edge of the slower one.

When both ratios are equal, every edge is a joint edge. In that case the pulse sits in the second half of every period of that clock, so it still repeats once per period.

Top module: `coin_sync_gen`

## Requirements
- R1: While `rst` is high, `syncN` is 1.
- R2: Let t be the number of rising `clk` edges since `rst` fell, with `syncN` sampled after edge t. Let L be the least common multiple of `divA` and `divC`, and F the smaller of the two ratios. If the ratios differ, `syncN` is 0 exactly when (t mod L) >= L - F, and 1 otherwise.
- R3: With different ratios, each low pulse lasts exactly F source cycles, one period of the faster divided clock.
- R4: With different ratios, `syncN` is 1 in every cycle where t mod L = 0, which is the joint rising edge.
- R5: With different ratios, `syncN` falls only in a cycle where t mod F = 0, which is a rising edge of the faster divided clock.
- R6: Swapping the values on `divA` and `divC` leaves the `syncN` waveform unchanged.
- R7: With equal ratios N, `syncN` is 0 exactly when (t mod N) >= floor(N/2), so one pulse occurs per period.
- R8: Raising `rst` in the middle of a run and releasing it restarts the sequence from t = 0.
- R9: `syncN` comes from a register and changes only after a rising `clk` edge. At t = 0, `syncN` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock shared with the dividers |
| rst | input | 1 | Synchronous active-high reset, shared with the dividers |
| divA | input | DIV_W | Bank A divide ratio, at least 2, held stable while out of reset |
| divC | input | DIV_W | Bank C divide ratio, at least 2, held stable while out of reset |
| syncN | output | 1 | Active-low sync pulse |

## Verification
The embedded properties check the local shape of the pulse on every cycle:
- the phase counters stay within bounds;
- both counters restart from zero when reset is released;
- the output is high at each joint edge;
- a pulse starts only on an edge of the faster clock and ends on its wrap;
- in equal-ratio mode, the output falls at the half-period phase.

Only the bench's sweep over every ratio pair from 2 to 8 shows the global placement. That is, it shows that the pulse appears once per least common multiple and nowhere else. The sweep also shows that swapping the ratios changes nothing, and that a reset in mid-run restarts the pattern.

// File: rtl/coin_sync_pkg.sv
package coin_sync_pkg;
  typedef struct packed {
    logic aFaster;    // bank A ratio strictly smaller than bank C
    logic equalMode;  // both ratios identical
    logic wrapA;      // bank A phase at its last source cycle
    logic wrapC;      // bank C phase at its last source cycle
  } ctlStrobeT;
endpackage

// File: rtl/coin_sync_ctl.sv
module coin_sync_ctl
  import coin_sync_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divC,
  output logic [DIV_W-1:0] phA,
  output logic [DIV_W-1:0] phC,
  output logic [DIV_W-1:0] nxtPhA,
  output logic [DIV_W-1:0] nxtPhC,
  output ctlStrobeT        strobe
);
  localparam int EXT_W = DIV_W + 1;

  logic [EXT_W-1:0] incA, incC;

  always_comb begin
    incA = {1'b0, phA} + EXT_W'(1);
    incC = {1'b0, phC} + EXT_W'(1);

    strobe.wrapA     = incA >= {1'b0, divA};
    strobe.wrapC     = incC >= {1'b0, divC};
    strobe.aFaster   = divA < divC;
    strobe.equalMode = divA == divC;

    nxtPhA = strobe.wrapA ? '0 : incA[DIV_W-1:0];
    nxtPhC = strobe.wrapC ? '0 : incC[DIV_W-1:0];
    if (rst) begin
      nxtPhA = '0;
      nxtPhC = '0;
    end
  end

  always_ff @(posedge clk) begin
    phA <= nxtPhA;
    phC <= nxtPhC;
  end

  AST_PHASE_A_BOUND: assert property (@(posedge clk) disable iff (rst)
    phA < divA);  // R2
  AST_PHASE_C_BOUND: assert property (@(posedge clk) disable iff (rst)
    phC < divC);  // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phA == '0 && phC == '0));  // R8
endmodule

// File: rtl/coin_sync_dp.sv
module coin_sync_dp
  import coin_sync_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divC,
  input  logic [DIV_W-1:0] phA,
  input  logic [DIV_W-1:0] phC,
  input  logic [DIV_W-1:0] nxtPhA,
  input  logic [DIV_W-1:0] nxtPhC,
  input  ctlStrobeT        strobe,
  output logic             syncN
);
  localparam int EXT_W = DIV_W + 1;

  logic [DIV_W-1:0] nFast, nSlow, pFast, pSlow, curFast;
  logic [EXT_W-1:0] reach;
  logic             lowNext, fastWrap;

  always_comb begin
    nFast    = strobe.aFaster ? divA   : divC;
    nSlow    = strobe.aFaster ? divC   : divA;
    pFast    = strobe.aFaster ? nxtPhA : nxtPhC;
    pSlow    = strobe.aFaster ? nxtPhC : nxtPhA;
    curFast  = strobe.aFaster ? phA    : phC;
    fastWrap = strobe.aFaster ? strobe.wrapA : strobe.wrapC;

    // Phase of the slower clock at the next rising edge of the faster one.
    reach = {1'b0, pSlow} + {1'b0, nFast} - {1'b0, pFast};

    if (strobe.equalMode) lowNext = pFast >= (nFast >> 1);
    else                  lowNext = reach == {1'b0, nSlow};
    if (rst) lowNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) syncN <= 1'b1;
    else     syncN <= !lowNext;
  end

  AST_HIGH_AT_JOINT: assert property (@(posedge clk) disable iff (rst)
    (phA == '0 && phC == '0) |-> syncN);  // R4
  AST_START_ON_FAST: assert property (@(posedge clk) disable iff (rst)
    (!strobe.equalMode && $fell(syncN)) |-> (curFast == '0));  // R5
  AST_END_ON_JOINT: assert property (@(posedge clk) disable iff (rst)
    (!strobe.equalMode && $rose(syncN)) |-> (phA == '0 && phC == '0));  // R3
  AST_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (!strobe.equalMode && !syncN && fastWrap) |=> syncN);  // R3
  AST_EQUAL_HALF: assert property (@(posedge clk) disable iff (rst)
    (strobe.equalMode && $fell(syncN)) |-> (curFast == (nFast >> 1)));  // R7
endmodule

// File: rtl/coin_sync_gen.sv
module coin_sync_gen
  import coin_sync_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divC,
  output logic             syncN
);
  logic [DIV_W-1:0] phA, phC, nxtPhA, nxtPhC;
  ctlStrobeT        strobe;

  coin_sync_ctl #(.DIV_W(DIV_W)) uCtl (
    .clk(clk), .rst(rst), .divA(divA), .divC(divC),
    .phA(phA), .phC(phC), .nxtPhA(nxtPhA), .nxtPhC(nxtPhC),
    .strobe(strobe)
  );

  coin_sync_dp #(.DIV_W(DIV_W)) uDp (
    .clk(clk), .rst(rst), .divA(divA), .divC(divC),
    .phA(phA), .phC(phC), .nxtPhA(nxtPhA), .nxtPhC(nxtPhC),
    .strobe(strobe), .syncN(syncN)
  );

  AST_RESET_HIGH: assert property (@(posedge clk)
    $past(rst) |-> syncN);  // R1
endmodule

// File: tb/tb_coin_sync_gen.sv
module tb_coin_sync_gen;
  localparam int DIV_W = 5;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DIV_W-1:0] divA = 5'd2;
  logic [DIV_W-1:0] divC = 5'd2;
  logic syncN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coin_sync_gen #(.DIV_W(DIV_W)) dut (
    .clk(clk), .rst(rst), .divA(divA), .divC(divC), .syncN(syncN)
  );

  function automatic int gcdOf(int a, int b);
    int x = a;
    int y = b;
    while (y != 0) begin
      int r = x % y;
      x = y;
      y = r;
    end
    return x;
  endfunction

  function automatic bit expectOut(int a, int c, int t);
    int l = (a * c) / gcdOf(a, c);
    int f = (a < c) ? a : c;
    if (a == c) return !((t % a) >= (a / 2));
    return !((t % l) >= (l - f));
  endfunction

  function automatic string tagOf(int a, int c, int t);
    int l = (a * c) / gcdOf(a, c);
    int f = (a < c) ? a : c;
    if (a == c) return "R7";
    if (t == 0) return "R9";
    if (t % l == 0) return "R4";
    if (t % l == l - f) return "R5";
    if (t % l > l - f) return "R3";
    if (a > c) return "R6";
    return "R2";
  endfunction

  task automatic check(bit exp, string tag, string info);
    checks++;
    if (syncN !== exp) begin
      errors++;
      $display("FAIL %s %s: syncN=%b expected=%b", tag, info, syncN, exp);
    end
  endtask

  task automatic runPair(int a, int c, int cycles);
    int l = (a * c) / gcdOf(a, c);
    rst = 1'b1;
    divA = DIV_W'(a);
    divC = DIV_W'(c);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(1'b1, "R1", $sformatf("reset a=%0d c=%0d", a, c));
    rst = 1'b0;
    check(expectOut(a, c, 0), "R9", $sformatf("t=0 a=%0d c=%0d", a, c));
    for (int t = 1; t <= cycles; t++) begin
      @(posedge clk);
      @(negedge clk);
      check(expectOut(a, c, t), tagOf(a, c, t),
            $sformatf("a=%0d c=%0d t=%0d L=%0d", a, c, t, l));
    end
  endtask

  initial begin
    for (int a = 2; a <= 8; a++) begin
      for (int c = 2; c <= 8; c++) begin
        runPair(a, c, 2 * ((a * c) / gcdOf(a, c)) + 3);
      end
    end
    // R8: reset in mid-run restarts the sequence
    runPair(3, 4, 7);
    runPair(3, 4, 30);
    runPair(6, 4, 5);
    runPair(6, 4, 28);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule